// File: doc/BRIEF.md
# MSI doorbell interrupt aggregator

This block gathers message-signalled interrupts arriving from a PCIe fabric and merges them into a single level interrupt toward the host interrupt controller. Every vector owns its own 32-bit doorbell word. A device raises vector n by posting the data word n to byte offset 4·n of the doorbell window. Each such write marks that vector pending. The host's handler later reads the doorbell word back, and that read retires the vector. No write to a status register takes part in clearing.

A second, small control window gives software three registers at byte offsets 0x0, 0x4 and 0x8. These are the pending vectors, a sticky flag for doorbell writes that fall outside the configured vectors, and a per-vector enable mask. The number of vectors is fixed when the block is built, with a limit of 32. No register reports that number. Both windows take word addresses: the byte-address bits [1:0] are dropped by the bus fabric upstream. Each window accepts one access per cycle and returns read data on the following cycle.

Top module: `msi_doorbell_agg`

## Requirements
- R1: A doorbell write to word n, with n below the configured vector count, sets bit n of the status register (control word 0, byte 0x0). The bit is visible from the cycle after the write.
- R2: A doorbell read of word n returns, one cycle later, the last data written to word n. The same read clears pending bit n.
- R3: When a doorbell write to vector n and a doorbell read of vector n occur in the same cycle, vector n stays pending. The read returns the data held before that write.
- R4: irq_out is high exactly when some vector is both pending and enabled by a 1 in its bit of the mask register (control word 2, byte 0x8). It follows the registers as a level.
- R5: Writing 0 to the mask register disables every vector, and irq_out then stays low whatever is pending.
- R6: Status bits at or above the vector count always read 0. A doorbell read of such a word returns 0, and a doorbell write to such a word leaves every status bit unchanged.
- R7: A doorbell write at or above the vector count sets bit 0 of the error register (control word 1, byte 0x4). The bit holds until a control write to that register with bit 0 set to 1. A control write with bit 0 at 0 keeps it. A new out-of-range write in the same cycle as the clearing write wins.
- R8: A control read returns its data one cycle later: status at word 0, error at word 1, mask at word 2, and 0 at word 3. Control writes to words 0 and 3 have no effect.
- R9: Reset clears all pending, error and mask bits, so irq_out is low after reset.
- R10: Mask bits at or above the vector count are not stored and read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| db_wr_en | input | 1 | Doorbell write strobe |
| db_wr_word | input | 5 | Doorbell word index of the write (byte offset / 4) |
| db_wr_data | input | 32 | Doorbell write data |
| db_rd_en | input | 1 | Doorbell read strobe |
| db_rd_word | input | 5 | Doorbell word index of the read |
| db_rd_data | output | 32 | Doorbell read data, valid the cycle after db_rd_en, otherwise 0 |
| cs_wr_en | input | 1 | Control write strobe |
| cs_rd_en | input | 1 | Control read strobe |
| cs_word | input | 2 | Control word index (byte offset / 4) |
| cs_wdata | input | 32 | Control write data |
| cs_rdata | output | 32 | Control read data, valid the cycle after cs_rd_en, otherwise 0 |
| irq_out | output | 1 | Aggregated level interrupt |

## Verification
Pending bits, the error flag, the mask and irq_out all change at the rising edge that captures the write. The bench drives every access on a falling edge and samples these results on the next falling edge. Control and doorbell read data pass through one more output register, so each read task samples on the falling edge that follows the strobe's capture edge, which is one cycle after issue. Same-cycle collisions are driven within a single falling-edge-to-falling-edge window, so that both channels land on the same rising edge.

// File: rtl/msi_agg_pkg.sv
// Shared sizes and control-word codes for the MSI doorbell aggregator.
// Assumes at most 32 vectors and 32-bit data on both windows.
package msi_agg_pkg;
    localparam int MAX_VEC = 32;
    localparam int DATA_W  = 32;
    localparam int IDX_W   = $clog2(MAX_VEC);

    // Control window word indices; the byte offset is four times the index.
    typedef enum logic [1:0] {
        CSR_STATUS = 2'd0,
        CSR_ERROR  = 2'd1,
        CSR_MASK   = 2'd2,
        CSR_SPARE  = 2'd3
    } csr_word_e;
endpackage

// File: rtl/msi_vec_bank.sv
// Per-vector doorbell storage and pending state.
// A write to word n stores the data and sets pending n. A read of word n
// returns the stored word one cycle later and clears pending n. When a write
// and a read hit the same vector, the write wins. Words at or above NUM_VEC
// hold nothing, read as 0, and raise oor_wr when written.
module msi_vec_bank
    import msi_agg_pkg::*;
#(
    parameter int NUM_VEC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               rd_en,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [DATA_W-1:0]  rd_data,
    output logic [NUM_VEC-1:0] pend,
    output logic               oor_wr
);
    localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_VEC);

    logic [DATA_W-1:0] words [NUM_VEC];
    logic [DATA_W-1:0] rd_sel;

    // Flag doorbell writes that address no configured vector.
    assign oor_wr = wr_en && !({1'b0, wr_idx} < LIMIT);

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
        logic              wr_hit;
        logic              rd_hit;
        logic [DATA_W-1:0] word_q;
        logic              pend_q;

        assign wr_hit = wr_en && (wr_idx == IDX_W'(v));
        assign rd_hit = rd_en && (rd_idx == IDX_W'(v));

        // Hold the last word posted to this vector.
        always_ff @(posedge clk) begin
            if (!rst_n)      word_q <= '0;
            else if (wr_hit) word_q <= wr_data;
        end

        // Pending: set by a write, cleared by a read, write has priority.
        always_ff @(posedge clk) begin
            if (!rst_n)      pend_q <= 1'b0;
            else if (wr_hit) pend_q <= 1'b1;
            else if (rd_hit) pend_q <= 1'b0;
        end

        assign words[v] = word_q;
        assign pend[v]  = pend_q;

        AST_RD_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && rd_idx == IDX_W'(v) && !(wr_en && wr_idx == IDX_W'(v))) |=> !pend[v]); // R2
        AST_COLLIDE_KEEPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && wr_en && rd_idx == IDX_W'(v) && wr_idx == IDX_W'(v)) |=> pend[v]); // R3
    end

    // Select the addressed word; unconfigured words give 0.
    always_comb begin
        rd_sel = '0;
        for (int v = 0; v < NUM_VEC; v++) begin
            if (rd_idx == IDX_W'(v)) rd_sel = words[v];
        end
    end

    // Register the read data; it is 0 in cycles without a read.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= rd_en ? rd_sel : '0;
    end

    AST_ONE_NEW_PEND_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(pend) <= $countones($past(pend)) + 1)); // R1
    AST_OOR_NO_NEW_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        oor_wr |=> ($countones(pend) <= $countones($past(pend)))); // R6
endmodule

// File: rtl/msi_csr_regs.sv
// Control window: status view, sticky error flag and enable mask.
// Assumes one access per cycle. Read data is registered and is 0 when no read
// is made. Writes to the status word and the spare word are dropped.
module msi_csr_regs
    import msi_agg_pkg::*;
#(
    parameter int NUM_VEC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_wr_en,
    input  logic               cs_rd_en,
    input  logic [1:0]         cs_word,
    input  logic [DATA_W-1:0]  cs_wdata,
    output logic [DATA_W-1:0]  cs_rdata,
    input  logic [NUM_VEC-1:0] pend,
    input  logic               oor_wr,
    output logic [NUM_VEC-1:0] mask,
    output logic               err
);
    csr_word_e         word;
    logic [DATA_W-1:0] rd_mux;

    assign word = csr_word_e'(cs_word);

    // Enable mask: only configured vector bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n)                             mask <= '0;
        else if (cs_wr_en && word == CSR_MASK)  mask <= cs_wdata[NUM_VEC-1:0];
    end

    // Sticky error: a new out-of-range write beats a write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                                             err <= 1'b0;
        else if (oor_wr)                                        err <= 1'b1;
        else if (cs_wr_en && word == CSR_ERROR && cs_wdata[0])  err <= 1'b0;
    end

    // Pick the register named by the word index.
    always_comb begin
        case (word)
            CSR_STATUS: rd_mux = DATA_W'(pend);
            CSR_ERROR:  rd_mux = DATA_W'(err);
            CSR_MASK:   rd_mux = DATA_W'(mask);
            default:    rd_mux = '0;
        endcase
    end

    // Register the control read data.
    always_ff @(posedge clk) begin
        if (!rst_n) cs_rdata <= '0;
        else        cs_rdata <= cs_rd_en ? rd_mux : '0;
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !(cs_wr_en && cs_word == 2'd1 && cs_wdata[0])) |=> err); // R7
    AST_MASK_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_wr_en && cs_word == 2'd2 && cs_wdata == '0) |=> (mask == '0)); // R5
endmodule

// File: rtl/msi_irq_merge.sv
// Reduces pending-and-enabled vectors to a single level interrupt.
// Purely combinational; its inputs come straight from registers.
module msi_irq_merge #(
    parameter int NUM_VEC = 32
) (
    input  logic [NUM_VEC-1:0] pend,
    input  logic [NUM_VEC-1:0] mask,
    output logic               irq
);
    // Any enabled pending vector raises the output.
    assign irq = |(pend & mask);
endmodule

// File: rtl/msi_doorbell_agg.sv
// MSI doorbell interrupt aggregator top level.
// Joins the doorbell bank, the control registers and the interrupt merge.
// Assumes NUM_VEC lies between 1 and 32 and that the upstream fabric has
// already turned byte addresses into word indices.
module msi_doorbell_agg
    import msi_agg_pkg::*;
#(
    parameter int NUM_VEC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              db_wr_en,
    input  logic [IDX_W-1:0]  db_wr_word,
    input  logic [DATA_W-1:0] db_wr_data,
    input  logic              db_rd_en,
    input  logic [IDX_W-1:0]  db_rd_word,
    output logic [DATA_W-1:0] db_rd_data,
    input  logic              cs_wr_en,
    input  logic              cs_rd_en,
    input  logic [1:0]        cs_word,
    input  logic [DATA_W-1:0] cs_wdata,
    output logic [DATA_W-1:0] cs_rdata,
    output logic              irq_out
);
    logic [NUM_VEC-1:0] pend;
    logic [NUM_VEC-1:0] mask;
    logic               oor_wr;
    logic               err;

    msi_vec_bank #(.NUM_VEC(NUM_VEC)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (db_wr_en),
        .wr_idx  (db_wr_word),
        .wr_data (db_wr_data),
        .rd_en   (db_rd_en),
        .rd_idx  (db_rd_word),
        .rd_data (db_rd_data),
        .pend    (pend),
        .oor_wr  (oor_wr)
    );

    msi_csr_regs #(.NUM_VEC(NUM_VEC)) u_csr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_wr_en (cs_wr_en),
        .cs_rd_en (cs_rd_en),
        .cs_word  (cs_word),
        .cs_wdata (cs_wdata),
        .cs_rdata (cs_rdata),
        .pend     (pend),
        .oor_wr   (oor_wr),
        .mask     (mask),
        .err      (err)
    );

    msi_irq_merge #(.NUM_VEC(NUM_VEC)) u_merge (
        .pend (pend),
        .mask (mask),
        .irq  (irq_out)
    );

    AST_MASK_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq_out); // R5
    AST_ERR_AFTER_OOR: assert property (@(posedge clk) disable iff (!rst_n)
        (db_wr_en && !(32'(db_wr_word) < NUM_VEC)) |=> err); // R7
endmodule

// File: tb/msi_doorbell_agg_bench.sv
// Self-checking bench: sweeps all doorbell words and mask bits of a
// six-vector build and compares against a model kept in the bench.
module msi_doorbell_agg_bench;
    import msi_agg_pkg::*;

    localparam int NV = 6;
    localparam logic [31:0] VMASK = 32'h0000_003F;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              db_wr_en = 1'b0;
    logic [IDX_W-1:0]  db_wr_word = '0;
    logic [DATA_W-1:0] db_wr_data = '0;
    logic              db_rd_en = 1'b0;
    logic [IDX_W-1:0]  db_rd_word = '0;
    logic [DATA_W-1:0] db_rd_data;
    logic              cs_wr_en = 1'b0;
    logic              cs_rd_en = 1'b0;
    logic [1:0]        cs_word = '0;
    logic [DATA_W-1:0] cs_wdata = '0;
    logic [DATA_W-1:0] cs_rdata;
    logic              irq_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [31:0] e_pend;
    logic [31:0] e_data [NV];
    logic [31:0] got;

    always #2 clk = ~clk;

    msi_doorbell_agg #(.NUM_VEC(NV)) u_msi_doorbell_agg (
        .clk(clk), .rst_n(rst_n),
        .db_wr_en(db_wr_en), .db_wr_word(db_wr_word), .db_wr_data(db_wr_data),
        .db_rd_en(db_rd_en), .db_rd_word(db_rd_word), .db_rd_data(db_rd_data),
        .cs_wr_en(cs_wr_en), .cs_rd_en(cs_rd_en), .cs_word(cs_word),
        .cs_wdata(cs_wdata), .cs_rdata(cs_rdata), .irq_out(irq_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic db_wr(input int i, input logic [31:0] d);
        @(negedge clk);
        db_wr_en = 1'b1; db_wr_word = IDX_W'(i); db_wr_data = d;
        @(negedge clk);
        db_wr_en = 1'b0;
    endtask

    task automatic db_rd(input int i, output logic [31:0] d);
        @(negedge clk);
        db_rd_en = 1'b1; db_rd_word = IDX_W'(i);
        @(negedge clk);
        db_rd_en = 1'b0;
        d = db_rd_data;
    endtask

    task automatic db_both(input int wi, input logic [31:0] wd, input int ri, output logic [31:0] d);
        @(negedge clk);
        db_wr_en = 1'b1; db_wr_word = IDX_W'(wi); db_wr_data = wd;
        db_rd_en = 1'b1; db_rd_word = IDX_W'(ri);
        @(negedge clk);
        db_wr_en = 1'b0; db_rd_en = 1'b0;
        d = db_rd_data;
    endtask

    task automatic cs_wr(input int w, input logic [31:0] d);
        @(negedge clk);
        cs_wr_en = 1'b1; cs_word = 2'(w); cs_wdata = d;
        @(negedge clk);
        cs_wr_en = 1'b0;
    endtask

    task automatic cs_rd(input int w, output logic [31:0] d);
        @(negedge clk);
        cs_rd_en = 1'b1; cs_word = 2'(w);
        @(negedge clk);
        cs_rd_en = 1'b0;
        d = cs_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        e_pend = '0;
        do_reset();

        // R9: reset state
        cs_rd(0, got); check("R9 status after reset", got, 32'h0);
        cs_rd(1, got); check("R9 error after reset", got, 32'h0);
        cs_rd(2, got); check("R9 mask after reset", got, 32'h0);
        check("R9 irq after reset", 32'(irq_out), 32'h0);

        // R1: ring every configured vector, status accumulates; irq masked (R4)
        for (int v = 0; v < NV; v++) begin
            e_data[v] = 32'hA500_0000 + 32'(v);
            db_wr(v, e_data[v]);
            e_pend[v] = 1'b1;
            check("R4 irq low while mask clear", 32'(irq_out), 32'h0);
            cs_rd(0, got); check("R1 status after doorbell write", got, e_pend);
        end

        // R6/R7: every out-of-range word, status untouched, error set
        cs_rd(1, got); check("R7 error clear before out-of-range", got, 32'h0);
        for (int w = NV; w < MAX_VEC; w++) begin
            db_wr(w, 32'(w));
            cs_rd(0, got); check("R6 status unchanged by out-of-range write", got, e_pend);
            cs_rd(1, got); check("R7 error set by out-of-range write", got, 32'h1);
        end
        db_rd(NV + 1, got); check("R6 out-of-range doorbell read", got, 32'h0);

        // R7: write-one-to-clear behaviour
        cs_wr(1, 32'hFFFF_FFFE);
        cs_rd(1, got); check("R7 error kept on write of 0", got, 32'h1);
        cs_wr(1, 32'h1);
        cs_rd(1, got); check("R7 error cleared by write of 1", got, 32'h0);
        db_wr(NV, 32'h0);
        @(negedge clk);
        cs_wr_en = 1'b1; cs_word = 2'd1; cs_wdata = 32'h1;
        db_wr_en = 1'b1; db_wr_word = IDX_W'(NV);
        @(negedge clk);
        cs_wr_en = 1'b0; db_wr_en = 1'b0;
        cs_rd(1, got); check("R7 set wins over clear", got, 32'h1);
        cs_wr(1, 32'h1);
        cs_rd(1, got); check("R7 error cleared again", got, 32'h0);

        // R4/R10: walk a single mask bit over all word bits
        for (int b = 0; b < 32; b++) begin
            cs_wr(2, 32'h1 << b);
            check("R4 irq with single enable", 32'(irq_out), (b < NV) ? 32'h1 : 32'h0);
            cs_rd(2, got); check("R10 mask readback", got, (32'h1 << b) & VMASK);
        end
        cs_wr(2, 32'hFFFF_FFFF);
        cs_rd(2, got); check("R10 mask all ones readback", got, VMASK);
        check("R4 irq with all enabled", 32'(irq_out), 32'h1);
        cs_wr(2, 32'h0);
        check("R5 irq low after mask cleared", 32'(irq_out), 32'h0);
        cs_rd(0, got); check("R5 pending kept while masked", got, e_pend);

        // R8: dropped writes and the spare word
        cs_wr(0, 32'h0);
        cs_rd(0, got); check("R8 status write ignored", got, e_pend);
        cs_wr(3, 32'hFFFF_FFFF);
        cs_rd(3, got); check("R8 spare word reads 0", got, 32'h0);
        cs_rd(2, got); check("R8 spare write leaves mask", got, 32'h0);

        // R2: read back each vector, which retires it
        cs_wr(2, VMASK);
        for (int v = 0; v < NV; v++) begin
            db_rd(v, got); check("R2 doorbell read data", got, e_data[v]);
            e_pend[v] = 1'b0;
            cs_rd(0, got); check("R2 status after clearing read", got, e_pend);
            check("R4 irq follows remaining pending", 32'(irq_out), (e_pend != 0) ? 32'h1 : 32'h0);
        end

        // R3: collision on one vector, then on two different vectors
        db_wr(2, 32'h1111_2222);
        db_both(2, 32'h3333_4444, 2, got);
        check("R3 collision read returns prior data", got, 32'h1111_2222);
        cs_rd(0, got); check("R3 collision keeps pending", got, 32'h0000_0004);
        db_rd(2, got); check("R2 read after collision", got, 32'h3333_4444);
        cs_rd(0, got); check("R2 cleared after collision", got, 32'h0);
        db_wr(4, 32'h0000_0004);
        db_both(3, 32'h0000_0003, 4, got);
        check("R2 read of other vector during write", got, 32'h0000_0004);
        cs_rd(0, got); check("R3 distinct vectors set and clear", got, 32'h0000_0008);

        // R9: reset with state present
        db_wr(NV, 32'h0);
        do_reset();
        cs_rd(0, got); check("R9 status after second reset", got, 32'h0);
        cs_rd(1, got); check("R9 error after second reset", got, 32'h0);
        cs_rd(2, got); check("R9 mask after second reset", got, 32'h0);
        check("R9 irq after second reset", 32'(irq_out), 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule